// File: doc/BRIEF.md
# Channel Refresh Sequencer with Burst Loading

This block keeps a bank of sample-and-hold outputs topped up from a small word memory. Each channel owns one memory word. On every sequencer tick the block picks the next channel, presents that channel's stored code to the shared converter, and pulses a one-cycle strobe together with the channel index so the matching hold stage samples. Word writes arrive already decoded (address plus data) from a serial front end while chip-select is low.

Holding chip-select low with both mode inputs low puts the block in burst mode. Refresh freezes, any number of words can be loaded, and on release scrolling picks up again at the channel that was being driven when it froze. The tick comes from an internal divider or from an external clock that is synchronised, edge-detected and divided by four. After reset the block runs a sweep that cannot be interrupted: it writes a fixed zero-volt code into every channel in turn on the internal tick and ignores serial writes until the sweep is done.

Top module: `refresh_seq`

## Requirements
- R1: While `rst` is high, `sha_strobe` is 0, `sweep_busy` is 1 and `dac_code` equals the zero-volt code 16'h4F2C.
- R2: After reset the block runs exactly NCH sweep ticks on channels 0, 1, ..., NCH-1 in that order. Each sweep strobe shows `dac_code` = 16'h4F2C. `sweep_busy` falls with the last sweep strobe.
- R3: The sweep always uses the internal tick, whatever `clk_sel` and `ext_clk_en` are set to. The burst-mode freeze does not stop it.
- R4: Serial writes presented during the sweep are discarded. Every channel reads back 16'h4F2C on the first loop after the sweep.
- R5: Outside the sweep, each tick gives one `sha_strobe` pulse that lasts one cycle. `sha_ch` steps by one modulo NCH, and `dac_code` holds that channel's stored word until the next strobe.
- R6: A write with `cs_n` = 0 and `wr_en` = 1 stores `wr_data` at `wr_addr`. The new word shows on that channel's next refresh.
- R7: Burst mode means `cs_n` = 0, `mode_immed` = 0 and `mode_c1` = 0, and no strobe occurs while it holds. With `cs_n` low and any other mode combination, or with `cs_n` high, refresh keeps running.
- R8: After a burst ends, the first strobe is on the channel that was current when the burst began. The (NCH+1)-th strobe is on that same channel again, and every channel is refreshed in between.
- R9: A burst write to the channel currently presented leaves `dac_code` unchanged for the rest of the freeze. The new word appears when that channel is refreshed on resume.
- R10: A write in the same cycle as the tick that reads that channel has no effect on that refresh, which shows the old word. The new word appears on the following loop.
- R11: With `ext_clk_en` or `clk_sel` high, outside the sweep, exactly one tick occurs per 4 rising edges of `eclk`.
- R12: With `clk_sel` high, outside the sweep, the internal tick is stopped. If `eclk` does not toggle, no strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also starts the zero-volt sweep |
| cs_n | input | 1 | Chip-select, active low |
| mode_immed | input | 1 | Mode input; low together with `mode_c1` and `cs_n` selects burst |
| mode_c1 | input | 1 | Mode input; see `mode_immed` |
| wr_en | input | 1 | Decoded word-write strobe |
| wr_addr | input | AW | Channel address of the write |
| wr_data | input | DW | Code to store |
| clk_sel | input | 1 | Selects the external tick and stops the internal one |
| ext_clk_en | input | 1 | Selects the external tick |
| eclk | input | 1 | External sequencer clock, asynchronous |
| dac_code | output | DW | Code of the channel in the current slot |
| sha_ch | output | AW | Index of the channel in the current slot |
| sha_strobe | output | 1 | One-cycle sample pulse for `sha_ch` |
| sweep_busy | output | 1 | High while the zero-volt sweep runs |

## Verification
The tightest overlap is a serial word write landing in the same clock cycle as the refresh read of that same channel, which happens when chip-select is low in a mode that does not freeze the sequencer. The bench locks onto the internal tick period by watching a strobe. It then times a write so that it is sampled on the exact edge of the next tick, and the target address is the channel after the one just strobed. The refresh that follows must show the old word and the next loop the new one. A second overlap, serial writes during the reset sweep, is judged by reading every channel back on the first loop after the sweep.

// File: rtl/refresh_seq_pkg.sv
package refresh_seq_pkg;

  // Which source is currently driving the sequencer tick.
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } tick_src_e;

endpackage

// File: rtl/seq_tick_gen.sv
module seq_tick_gen
  import refresh_seq_pkg::*;
#(
  parameter int INT_DIV  = 10,
  parameter int ECLK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic eclk,
  input  logic ext_req,
  input  logic osc_off,
  input  logic force_int,
  output logic tick
);

  localparam int CW = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
  localparam int EW = (ECLK_DIV > 1) ? $clog2(ECLK_DIV) : 1;

  logic [CW-1:0] osc_cnt;
  logic          osc_run;
  logic          osc_tick;
  logic [2:0]    eclk_sync;
  logic          eclk_rise;
  logic [EW-1:0] edge_cnt;
  logic          ext_tick;
  tick_src_e     src;

  // Internal divider: stopped when the oscillator is switched off,
  // unless the reset sweep forces it on.
  assign osc_run  = force_int || !osc_off;
  assign osc_tick = osc_run && (osc_cnt == CW'(INT_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      osc_cnt <= '0;
    end else if (osc_run) begin
      osc_cnt <= osc_tick ? '0 : osc_cnt + 1'b1;
    end
  end

  // External clock: two-flop synchroniser plus one history flop for edges.
  always_ff @(posedge clk) begin
    if (rst) eclk_sync <= '0;
    else     eclk_sync <= {eclk_sync[1:0], eclk};
  end

  assign eclk_rise = eclk_sync[1] & ~eclk_sync[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_cnt <= '0;
    end else if (eclk_rise) begin
      edge_cnt <= (edge_cnt == EW'(ECLK_DIV - 1)) ? '0 : edge_cnt + 1'b1;
    end
  end

  assign ext_tick = eclk_rise && (edge_cnt == EW'(ECLK_DIV - 1));

  assign src  = (ext_req && !force_int) ? SRC_EXT : SRC_INT;
  assign tick = (src == SRC_EXT) ? ext_tick : osc_tick;

  AST_OSC_HELD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (osc_off && !force_int) |=> $stable(osc_cnt)); // R12

endmodule

// File: rtl/seq_chan_ram.sv
module seq_chan_ram #(
  parameter int DEPTH = 32,
  parameter int W     = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  localparam logic [AW:0] DEPTH_L = (AW + 1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic         waddr_ok;

  assign waddr_ok = ({1'b0, waddr} < DEPTH_L);

  // Simple dual port, read-first, registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we && waddr_ok) mem[waddr] <= wdata;
    if (re)             rdata      <= mem[raddr];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (we && waddr_ok) |=> (mem[$past(waddr)] == $past(wdata))); // R6

endmodule

// File: rtl/refresh_seq.sv
module refresh_seq
  import refresh_seq_pkg::*;
#(
  parameter int            NCH        = 32,
  parameter int            DW         = 16,
  parameter int            INT_DIV    = 10,
  parameter int            ECLK_DIV   = 4,
  parameter logic [DW-1:0] RESET_CODE = DW'(16'h4F2C),
  localparam int           AW         = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          mode_immed,
  input  logic          mode_c1,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          clk_sel,
  input  logic          ext_clk_en,
  input  logic          eclk,
  output logic [DW-1:0] dac_code,
  output logic [AW-1:0] sha_ch,
  output logic          sha_strobe,
  output logic          sweep_busy
);

  localparam logic [AW-1:0] LAST_CH = AW'(NCH - 1);

  logic          tick;
  logic          burst;
  logic          halt;
  logic          adv;
  logic          redo;
  logic          swp_q;
  logic [AW-1:0] cur;
  logic [AW-1:0] nxt;
  logic [AW-1:0] swp_cnt;
  logic          ram_we;
  logic [AW-1:0] ram_waddr;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_q;

  seq_tick_gen #(
    .INT_DIV  (INT_DIV),
    .ECLK_DIV (ECLK_DIV)
  ) u_tick (
    .clk       (clk),
    .rst       (rst),
    .eclk      (eclk),
    .ext_req   (ext_clk_en | clk_sel),
    .osc_off   (clk_sel),
    .force_int (sweep_busy),
    .tick      (tick)
  );

  // Burst freezes scrolling; the sweep cannot be frozen.
  assign burst = !cs_n && !mode_immed && !mode_c1;
  assign halt  = burst && !sweep_busy;
  assign adv   = tick && !halt;

  // Next slot: repeat the frozen channel once after a burst, else step.
  always_comb begin
    if (redo && !sweep_busy) nxt = cur;
    else if (cur == LAST_CH) nxt = '0;
    else                     nxt = cur + 1'b1;
  end

  // Single write port: the sweep owns it; serial writes are locked out.
  always_comb begin
    if (sweep_busy) begin
      ram_we    = adv;
      ram_waddr = nxt;
      ram_wdata = RESET_CODE;
    end else begin
      ram_we    = wr_en && !cs_n;
      ram_waddr = wr_addr;
      ram_wdata = wr_data;
    end
  end

  seq_chan_ram #(
    .DEPTH (NCH),
    .W     (DW)
  ) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (adv),
    .raddr (nxt),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur        <= LAST_CH;
      redo       <= 1'b0;
      sweep_busy <= 1'b1;
      swp_cnt    <= '0;
      sha_strobe <= 1'b0;
      swp_q      <= 1'b1;
    end else begin
      sha_strobe <= adv;
      if (adv) begin
        cur   <= nxt;
        redo  <= 1'b0;
        swp_q <= sweep_busy;
        if (sweep_busy) begin
          swp_cnt <= swp_cnt + 1'b1;
          if (swp_cnt == LAST_CH) sweep_busy <= 1'b0;
        end
      end else if (halt) begin
        redo <= 1'b1;
      end
    end
  end

  // During the sweep the RAM read races the sweep write, so show the code.
  assign dac_code = swp_q ? RESET_CODE : ram_q;
  assign sha_ch   = cur;

  AST_BURST_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !mode_immed && !mode_c1 && !sweep_busy) |=> !sha_strobe); // R7

  AST_SWEEP_SHOWS_CODE: assert property (@(posedge clk) disable iff (rst)
    (sha_strobe && $past(sweep_busy)) |-> (dac_code == RESET_CODE)); // R2

endmodule

// File: tb/refresh_seq_bench.sv
module refresh_seq_bench;

  localparam int NCH = 8;
  localparam int DW = 16;
  localparam int INT_DIV = 4;
  localparam int ECLK_DIV = 4;
  localparam int AW = 3;
  localparam logic [15:0] ZC = 16'h4F2C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, imm = 1'b1, c1 = 1'b1, wr_en = 1'b0;
  logic clk_sel = 1'b0, c0 = 1'b0, eclk = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] dac_code;
  logic [AW-1:0] sha_ch;
  logic sha_strobe, sweep_busy;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  refresh_seq #(
    .NCH(NCH), .DW(DW), .INT_DIV(INT_DIV), .ECLK_DIV(ECLK_DIV)
  ) u_refresh_seq (
    .clk(clk), .rst(rst), .cs_n(cs_n), .mode_immed(imm), .mode_c1(c1),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clk_sel(clk_sel), .ext_clk_en(c0), .eclk(eclk),
    .dac_code(dac_code), .sha_ch(sha_ch), .sha_strobe(sha_strobe),
    .sweep_busy(sweep_busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Bench memory model; model_prev is what a read on the last edge saw.
  logic [DW-1:0] model [NCH];
  logic [DW-1:0] model_prev [NCH];
  logic model_wr_ok = 1'b0;

  always @(posedge clk) begin
    model_prev <= model;
    if (rst) begin
      for (int i = 0; i < NCH; i++) model[i] <= ZC;
    end else if (wr_en && !cs_n && model_wr_ok) begin
      model[wr_addr] <= wr_data;
    end
  end

  // Strobe monitor: order (R5/R8) and value (tag per phase).
  int strobes = 0;
  logic [AW-1:0] last_ch = AW'(NCH - 1);
  logic [AW-1:0] mon_exp;
  logic expect_redo = 1'b0;
  string mon_tag = "R2";

  always @(negedge clk) begin
    if (!rst && sha_strobe) begin
      mon_exp = expect_redo ? last_ch : AW'((int'(last_ch) + 1) % NCH);
      check(sha_ch == mon_exp, expect_redo ? "R8" : "R5", "channel order",
            32'(sha_ch), 32'(mon_exp));
      check(dac_code == model_prev[sha_ch], mon_tag, "strobe code",
            32'(dac_code), 32'(model_prev[sha_ch]));
      last_ch = sha_ch;
      expect_redo = 1'b0;
      strobes++;
    end
  end

  task automatic wait_strobes(input int n);
    int s;
    s = strobes;
    while (strobes < s + n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic eclk_rises(input int n);
    for (int k = 0; k < n; k++) begin
      eclk = 1'b1;
      repeat (3) @(negedge clk);
      eclk = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  function automatic logic [15:0] burst_word(input int ch);
    return 16'hA000 ^ 16'(ch * 16'h0357);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int s0;
    int ich;
    int tgt;
    logic [15:0] hold;
    logic [15:0] oldw;

    // R1 reset state, with external select and cs low to prove R3/R4.
    clk_sel = 1'b1;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    check(sha_strobe == 1'b0, "R1", "strobe in reset", 32'(sha_strobe), 0);
    check(sweep_busy == 1'b1, "R1", "busy in reset", 32'(sweep_busy), 1);
    check(dac_code == ZC, "R1", "code in reset", 32'(dac_code), 32'(ZC));
    s0 = strobes;
    @(negedge clk);
    rst = 1'b0;
    // R4: writes during the sweep must be discarded.
    for (int k = 0; k < 6; k++) begin
      wr_en = 1'b1; wr_addr = AW'(k); wr_data = 16'h1234 + 16'(k);
      @(negedge clk);
    end
    wr_en = 1'b0;
    while (sweep_busy) @(negedge clk);
    idle(2);
    check(strobes - s0 == NCH, "R3", "sweep ticks with clk_sel high",
          32'(strobes - s0), NCH);
    check(last_ch == AW'(NCH - 1), "R2", "sweep last channel",
          32'(last_ch), NCH - 1);
    model_wr_ok = 1'b1;

    // R12: oscillator off and eclk idle -> nothing.
    s0 = strobes;
    idle(60);
    check(strobes == s0, "R12", "strobes with clk_sel high, eclk idle",
          32'(strobes - s0), 0);

    // First loop after sweep: all channels still zero-volt (R4).
    mon_tag = "R4";
    clk_sel = 1'b0;
    cs_n = 1'b1;
    wait_strobes(NCH);
    mon_tag = "R5";

    // R7: cs low in non-burst modes, and burst code with cs high, keep running.
    for (int m = 0; m < 4; m++) begin
      cs_n = (m == 3);
      imm = (m == 0 || m == 2);
      c1 = (m == 1 || m == 2) || (m == 3) ? (m != 3) : 1'b0;
      if (m == 3) begin imm = 1'b0; c1 = 1'b0; end
      s0 = strobes;
      idle(3 * INT_DIV);
      check(strobes - s0 >= 2, "R7", "running in non-burst combination",
            32'(strobes - s0), 2);
    end
    cs_n = 1'b1; imm = 1'b1; c1 = 1'b1;

    // Burst: freeze, load every channel, resume (R7, R8, R9).
    mon_tag = "R9";
    wait_strobes(1);
    cs_n = 1'b0; imm = 1'b0; c1 = 1'b0;
    expect_redo = 1'b1;
    ich = int'(sha_ch);
    hold = dac_code;
    s0 = strobes;
    for (int ch = 0; ch < NCH; ch++) begin
      wr_en = 1'b1; wr_addr = AW'(ch); wr_data = burst_word(ch);
      @(negedge clk);
    end
    wr_en = 1'b0;
    idle(40);
    check(strobes == s0, "R7", "strobes during burst", 32'(strobes - s0), 0);
    check(dac_code == hold, "R9", "code held after write to current channel",
          32'(dac_code), 32'(hold));
    cs_n = 1'b1; imm = 1'b1; c1 = 1'b1;
    wait_strobes(1);
    check(int'(sha_ch) == ich, "R8", "resume channel", 32'(sha_ch), 32'(ich));
    check(dac_code == burst_word(ich), "R9", "new word on resume",
          32'(dac_code), 32'(burst_word(ich)));
    mon_tag = "R6";
    wait_strobes(NCH);
    check(int'(sha_ch) == ich, "R8", "channel after NCH+1 strobes",
          32'(sha_ch), 32'(ich));

    // R10: write sampled on the very edge that reads the channel.
    mon_tag = "R10";
    cs_n = 1'b0;
    wait_strobes(1);
    tgt = (int'(sha_ch) + 1) % NCH;
    oldw = model[tgt];
    repeat (3) @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(tgt); wr_data = 16'h5A5A;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check(sha_strobe && int'(sha_ch) == tgt, "R10", "collision slot",
          32'(sha_ch), 32'(tgt));
    check(dac_code == oldw, "R10", "old word in collision slot",
          32'(dac_code), 32'(oldw));
    cs_n = 1'b1;
    wait_strobes(NCH);
    check(int'(sha_ch) == tgt && dac_code == 16'h5A5A, "R10",
          "new word next loop", 32'(dac_code), 32'h5A5A);

    // R11: external tick through ext_clk_en, then through clk_sel.
    mon_tag = "R11";
    c0 = 1'b1;
    s0 = strobes;
    eclk_rises(40);
    idle(10);
    check(strobes - s0 == 40 / ECLK_DIV, "R11", "ticks from 40 eclk rises",
          32'(strobes - s0), 32'(40 / ECLK_DIV));
    c0 = 1'b0;
    clk_sel = 1'b1;
    s0 = strobes;
    eclk_rises(8);
    idle(10);
    check(strobes - s0 == 8 / ECLK_DIV, "R11", "ticks from 8 eclk rises",
          32'(strobes - s0), 32'(8 / ECLK_DIV));
    s0 = strobes;
    idle(80);
    check(strobes == s0, "R12", "stopped with clk_sel high",
          32'(strobes - s0), 0);
    clk_sel = 1'b0;
    idle(4 * INT_DIV);
    check(strobes - s0 >= 3, "R12", "internal tick back after clk_sel low",
          32'(strobes - s0), 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule